// File: doc/BRIEF.md
# Two-Point Supply Regulator Switch Controller

This block decides when the bypass switch of a charge-pump supply regulator conducts. Outside operating mode the switch is kept open. Inside operating mode it compares digitised supply-level flags against a hysteresis band and turns the switch on or off. It does this in step with the falling edges of the half-bridge low-side logic input, so that the switch never changes in the middle of a switching phase. The one exception is an over-voltage flag: it closes the switch at once, without waiting for an edge.

The three comparator flags, the low-side logic input and the low-side gate feedback are asynchronous to the block clock. They pass through a parameterised synchroniser, and all decisions are taken on the synchronised copies. The thresholds only take effect once the low-side gate has produced its first falling edge after operating mode was entered. Between edges the latest threshold request is held as a pending action. An off request overrides a pending on request, and the reverse also holds.

Top module: `tpr_switch_ctrl`

## Requirements
- R1: While `op_mode` is 0, `sw_on` is 0 from the next clock edge. The arming state and any pending request are also cleared, so that re-entering operating mode needs a fresh low-side gate falling edge.
- R2: In operating mode, a synchronised `vcc_over_prot` of 1 sets `sw_on` to 1 on the next clock edge. This needs no arming and no low-side edge, and it takes priority over every other flag.
- R3: When armed, and `vcc_over_on`=1 with `vcc_under_off`=0, `sw_on` becomes 1 at the next falling edge of the synchronised `lo_in`. It does not change before that edge.
- R4: When armed and `vcc_under_off`=1, `sw_on` becomes 0 at the next falling edge of the synchronised `lo_in`. Without `vcc_over_prot` it does not change before that edge.
- R5: When armed, with both threshold flags at 0 and no request pending, a falling edge of `lo_in` leaves `sw_on` unchanged.
- R6: Before the first falling edge of the synchronised `lo_gate` in the current operating-mode period, the two threshold flags and `lo_in` edges have no effect on `sw_on`.
- R7: A threshold request seen between edges is held until the next `lo_in` falling edge, even if both flags return to 0 in the meantime. A later opposite request replaces it: an off condition cancels a pending on, and an on condition cancels a pending off. Every `lo_in` falling edge consumes the pending request.
- R8: If `vcc_under_off` and `vcc_over_on` are both 1, the off request wins.
- R9: Each asynchronous input passes through `SYNC_STAGES` flip-flops. A level change on `vcc_over_prot`, or a 1-to-0 change on `lo_in`, shows on `sw_on` at the (`SYNC_STAGES`+1)th rising clock edge after it. A falling edge is a synchronised value of 1 followed by 0 on the next cycle.
- R10: While `rst_n` is 0, `sw_on` is 0, the block is unarmed and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mode | input | 1 | Operating-mode enable (synchronous to `clk`) |
| vcc_over_prot | input | 1 | Supply above protection level (asynchronous) |
| vcc_over_on | input | 1 | Supply above regulator-on level (asynchronous) |
| vcc_under_off | input | 1 | Supply below regulator-off level (asynchronous) |
| lo_in | input | 1 | Low-side logic input (asynchronous) |
| lo_gate | input | 1 | Low-side gate output feedback (asynchronous) |
| sw_on | output | 1 | Regulator switch control, 1 = conducting |

## Verification
The assertions check the following on every cycle:
- the forced-off state outside operating mode;
- the one-cycle response to the protection flag;
- that the switch holds between low-side edges;
- that nothing moves while unarmed;
- the on, off and off-over-on outcomes at an armed edge.

Pending requests that survive a return to the band or are cancelled by an opposite request span many cycles, so only the bench's scenarios show them. The same applies to re-arming after a mode exit and to the exact input-to-output latency through the synchroniser.

// File: rtl/tpr_pkg.sv
package tpr_pkg;

  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_ON   = 2'd1,
    REQ_OFF  = 2'd2
  } req_e;

  // Request implied by the current supply flags; off outranks on.
  function automatic req_e level_req(input logic armed, input logic above_on,
                                     input logic below_off);
    if (!armed)         return REQ_NONE;
    else if (below_off) return REQ_OFF;
    else if (above_on)  return REQ_ON;
    else                return REQ_NONE;
  endfunction

  // A fresh request replaces the held one; otherwise the held one survives.
  function automatic req_e merge_req(input req_e now_r, input req_e held_r);
    return (now_r != REQ_NONE) ? now_r : held_r;
  endfunction

  // Switch state after applying a request at a low-side falling edge.
  function automatic logic apply_req(input logic sw, input req_e r);
    case (r)
      REQ_ON:  return 1'b1;
      REQ_OFF: return 1'b0;
      default: return sw;
    endcase
  endfunction

  // Full next-state rule of the switch register.
  function automatic logic next_sw(input logic op, input logic prot,
                                   input logic edge_seen, input logic sw,
                                   input req_e r);
    if (!op)            return 1'b0;
    else if (prot)      return 1'b1;
    else if (edge_seen) return apply_req(sw, r);
    else                return sw;
  endfunction

endpackage

// File: rtl/tpr_sync.sv
module tpr_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sr <= '0;
        end else begin
          sr[0] <= d;
          for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
        end
      end
      assign q = sr[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/tpr_fall_det.sv
module tpr_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fall
);
  logic prev_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end
  assign fall = prev_q & ~lvl;
endmodule

// File: rtl/tpr_req_tracker.sv
module tpr_req_tracker
  import tpr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic op_mode,
  input  logic gate_fall,
  input  logic lo_fall,
  input  logic above_on,
  input  logic below_off,
  output logic armed,
  output req_e eff_req
);
  logic armed_q;
  req_e pend_q;
  req_e now_req;

  assign now_req = level_req(armed_q, above_on, below_off);
  assign eff_req = merge_req(now_req, pend_q);
  assign armed   = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pend_q  <= REQ_NONE;
    end else if (!op_mode) begin
      armed_q <= 1'b0;
      pend_q  <= REQ_NONE;
    end else begin
      armed_q <= armed_q | gate_fall;
      pend_q  <= lo_fall ? REQ_NONE : eff_req;
    end
  end
endmodule

// File: rtl/tpr_switch_ctrl.sv
module tpr_switch_ctrl
  import tpr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic op_mode,
  input  logic vcc_over_prot,
  input  logic vcc_over_on,
  input  logic vcc_under_off,
  input  logic lo_in,
  input  logic lo_gate,
  output logic sw_on
);
  localparam int NUM_ASYNC = 5;

  logic [NUM_ASYNC-1:0] raw_bus, sync_bus;
  logic prot_s, on_s, off_s, lo_s, gate_s;
  logic lo_fall, gate_fall, armed_q;
  req_e eff_req;
  logic sw_q;

  assign raw_bus = {lo_gate, lo_in, vcc_under_off, vcc_over_on, vcc_over_prot};

  tpr_sync #(.WIDTH(NUM_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
  );

  assign prot_s = sync_bus[0];
  assign on_s   = sync_bus[1];
  assign off_s  = sync_bus[2];
  assign lo_s   = sync_bus[3];
  assign gate_s = sync_bus[4];

  tpr_fall_det u_lo_fall (
    .clk(clk), .rst_n(rst_n), .lvl(lo_s), .fall(lo_fall)
  );

  tpr_fall_det u_gate_fall (
    .clk(clk), .rst_n(rst_n), .lvl(gate_s), .fall(gate_fall)
  );

  tpr_req_tracker u_track (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode),
    .gate_fall(gate_fall), .lo_fall(lo_fall),
    .above_on(on_s), .below_off(off_s),
    .armed(armed_q), .eff_req(eff_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= 1'b0;
    else        sw_q <= next_sw(op_mode, prot_s, lo_fall, sw_q, eff_req);
  end

  assign sw_on = sw_q;
endmodule

// File: rtl/tpr_switch_ctrl_chk.sv
module tpr_switch_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic op_mode,
  input logic prot_s,
  input logic on_s,
  input logic off_s,
  input logic lo_fall,
  input logic armed,
  input logic sw_on
);
  AST_OFF_OUTSIDE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !op_mode |=> !sw_on); // R1

  AST_PROT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode && prot_s) |=> sw_on); // R2

  AST_HOLD_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode && !prot_s && !lo_fall) |=> $stable(sw_on)); // R3

  AST_ON_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode && armed && lo_fall && on_s && !off_s) |=> sw_on); // R3

  AST_OFF_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode && armed && lo_fall && off_s && !prot_s) |=> !sw_on); // R4

  AST_UNARMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode && !armed && !prot_s) |=> $stable(sw_on)); // R6

  AST_OFF_BEATS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode && armed && lo_fall && off_s && on_s && !prot_s) |=> !sw_on); // R8
endmodule

bind tpr_switch_ctrl tpr_switch_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .prot_s(prot_s),
  .on_s(on_s), .off_s(off_s), .lo_fall(lo_fall), .armed(armed_q),
  .sw_on(sw_on)
);

// File: tb/tpr_switch_ctrl_tb.sv
module tpr_switch_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;
  localparam int LAT = SYNC + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_mode = 1'b0;
  logic prot = 1'b0, on_f = 1'b0, off_f = 1'b0, lo_in = 1'b0, lo_gate = 1'b0;
  logic sw_on;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tpr_switch_ctrl #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .vcc_over_prot(prot),
    .vcc_over_on(on_f), .vcc_under_off(off_f), .lo_in(lo_in),
    .lo_gate(lo_gate), .sw_on(sw_on)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic exp);
    checks++;
    if (sw_on !== exp) begin
      errors++;
      $display("FAIL %s: sw_on=%0b expected %0b", tag, sw_on, exp);
    end
  endtask

  task automatic pulse_lo();
    lo_in = 1'b1; wait_cyc(LAT);
    lo_in = 1'b0; wait_cyc(LAT + 1);
  endtask

  task automatic pulse_gate();
    lo_gate = 1'b1; wait_cyc(LAT);
    lo_gate = 1'b0; wait_cyc(LAT + 1);
  endtask

  task automatic set_flags(input logic p, input logic o, input logic f);
    prot = p; on_f = o; off_f = f;
  endtask

  // Outcome at an armed edge: off wins, then on, else hold.
  function automatic logic edge_result(input logic start, input logic o, input logic f);
    if (f) return 1'b0;
    if (o) return 1'b1;
    return start;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, sw_on=%0b expected finish", sw_on);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    op_mode = 1'b1; set_flags(1'b1, 1'b1, 1'b0);
    wait_cyc(5);
    check("R10 reset holds switch off", 1'b0);
    set_flags(1'b0, 1'b0, 1'b0);
    wait_cyc(1);
    rst_n = 1'b1;
    wait_cyc(LAT + 1);
    check("R10 off after reset release", 1'b0);

    // Unarmed: thresholds and edges ignored, protection still acts.
    set_flags(1'b0, 1'b1, 1'b0); wait_cyc(LAT + 1); pulse_lo();
    check("R6 on request ignored before arming", 1'b0);
    set_flags(1'b1, 1'b1, 1'b0); wait_cyc(LAT + 1);
    check("R2 protection closes while unarmed", 1'b1);
    set_flags(1'b0, 1'b0, 1'b1); wait_cyc(LAT + 1); pulse_lo();
    check("R6 off request ignored before arming", 1'b1);
    op_mode = 1'b0; wait_cyc(1);
    check("R1 mode exit opens switch", 1'b0);

    // Arm and sweep start state x flag combination.
    op_mode = 1'b1; set_flags(1'b0, 1'b0, 1'b0); wait_cyc(2);
    pulse_gate();
    for (int s = 0; s < 2; s++) begin
      for (int f = 0; f < 4; f++) begin
        logic st, o, fo;
        st = s[0]; o = f[0]; fo = f[1];
        set_flags(1'b0, st, ~st); wait_cyc(LAT + 1); pulse_lo();
        set_flags(1'b0, o, fo); wait_cyc(LAT + 2);
        check(st ? "R4 no change before edge (start on)" : "R3 no change before edge (start off)", st);
        pulse_lo();
        case (f)
          0: check("R5 band holds at edge", edge_result(st, o, fo));
          1: check("R3 on at edge", edge_result(st, o, fo));
          2: check("R4 off at edge", edge_result(st, o, fo));
          default: check("R8 off beats on at edge", edge_result(st, o, fo));
        endcase
      end
    end

    // Pending behaviour; switch is now off.
    set_flags(1'b0, 1'b1, 1'b0); wait_cyc(LAT + 1);
    set_flags(1'b0, 1'b0, 1'b0); wait_cyc(LAT + 1); pulse_lo();
    check("R7 pending on survives return to band", 1'b1);
    set_flags(1'b0, 1'b0, 1'b1); wait_cyc(LAT + 1);
    set_flags(1'b0, 1'b1, 1'b0); wait_cyc(LAT + 1);
    set_flags(1'b0, 1'b0, 1'b0); wait_cyc(LAT + 1); pulse_lo();
    check("R7 later on cancels pending off", 1'b1);
    set_flags(1'b0, 1'b0, 1'b1); wait_cyc(LAT + 1); pulse_lo();
    check("R4 off at edge before cancel test", 1'b0);
    set_flags(1'b0, 1'b1, 1'b0); wait_cyc(LAT + 1);
    set_flags(1'b0, 1'b0, 1'b1); wait_cyc(LAT + 1);
    set_flags(1'b0, 1'b0, 1'b0); wait_cyc(LAT + 1); pulse_lo();
    check("R7 off cancels pending on", 1'b0);
    pulse_lo();
    check("R7 edge consumed pending request", 1'b0);

    // Latency of the protection path.
    prot = 1'b1; wait_cyc(SYNC);
    check("R9 protection not yet visible", 1'b0);
    wait_cyc(1);
    check("R9 protection visible after SYNC+1 edges", 1'b1);
    set_flags(1'b1, 1'b0, 1'b1); wait_cyc(LAT + 1); pulse_lo();
    check("R2 protection outranks off at edge", 1'b1);
    prot = 1'b0; wait_cyc(LAT + 1); pulse_lo();
    check("R4 off once protection drops", 1'b0);

    // Latency of the edge path.
    set_flags(1'b0, 1'b1, 1'b0); lo_in = 1'b1; wait_cyc(LAT + 1);
    lo_in = 1'b0; wait_cyc(SYNC);
    check("R9 edge action not yet visible", 1'b0);
    wait_cyc(1);
    check("R9 edge action after SYNC+1 edges", 1'b1);

    // Mode exit clears arming.
    op_mode = 1'b0; wait_cyc(1);
    check("R1 switch opens on mode exit", 1'b0);
    op_mode = 1'b1; wait_cyc(LAT + 1); pulse_lo();
    check("R1 re-entry needs new arming edge", 1'b0);
    pulse_gate(); pulse_lo();
    check("R3 on after re-arming", 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule